// File: doc/BRIEF.md
# Timekeeping Register Window with Snapshot Freeze

This block sits on a synchronous bytewide memory port and gives software access to two things through one address space. The top eight byte addresses form a window onto the calendar clock: one control byte followed by seven BCD time fields. All lower addresses go to ordinary on-chip RAM. The running calendar counters live outside this block. They present their current values on a set of snapshot inputs and pulse a once-per-second tick.

The block holds a second, software-visible copy of the time fields. While the copy is running, it reloads from the live counters on every tick. Software can set a freeze bit in the control byte to pin the copy to the count that was current when the freeze was written. It can then read all seven fields without any of them moving underneath it, while the live counters go on counting outside. When the freeze bit is cleared, every field reloads together on the next tick.

The address width is a parameter. The clock window always occupies the eight highest addresses of the space.

Top module: `rtc_window`

## Requirements
- R1: A write to an address below the top eight stores the byte in RAM. A read of that address returns the stored byte on `rdata` after the clock edge that samples `rd_en`.
- R2: A read of one of the eight highest addresses returns clock-window contents, never RAM contents.
- R3: The window layout by offset from its base is: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Time inputs are BCD bytes.
- R4: While not frozen, the visible copy loads all seven live fields at the clock edge where `tick` is high. A read issued on the following cycle returns the new values.
- R5: Writing a byte with bit 6 set to control offset 0, while not already frozen, loads the visible copy from the live inputs at that edge and sets the freeze bit.
- R6: While the freeze bit is set, ticks and changes on the live inputs leave every visible field unchanged.
- R7: Writing the control byte with bit 6 clear releases the freeze. The visible fields stay as they were until the next tick, and at that tick all seven reload together.
- R8: Unused bits read as zero. The masks are seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F and year 0xFF. The control byte reads as 0x40 when frozen and 0x00 otherwise.
- R9: Writes to offsets 1 to 7 are ignored: they change neither the visible fields nor any RAM byte.
- R10: After reset the freeze bit is clear, every visible field is zero and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe; `rdata` updates at the sampling edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tick | input | 1 | One-second pulse from the counting chain |
| live_sec | input | 8 | Running seconds, BCD |
| live_min | input | 8 | Running minutes, BCD |
| live_hour | input | 8 | Running hours (24 h), BCD |
| live_day | input | 8 | Running day of week |
| live_date | input | 8 | Running day of month, BCD |
| live_month | input | 8 | Running month, BCD |
| live_year | input | 8 | Running year, BCD |

## Verification
Every result is due one clock edge after its stimulus.

- Read data appears after the edge that samples `rd_en`.
- A tick or a freeze write changes the visible copy at the edge that samples it, so a read issued on the next cycle returns the new values.

The bench drives all inputs at the falling edge and keeps each strobe high for exactly one rising edge. It samples `rdata` at the following falling edge, half a cycle after the register has settled. The freeze and release scenarios change the live inputs only after the capturing edge. Each scenario therefore has exactly one correct snapshot to compare against.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
  localparam int BYTE_W     = 8;
  localparam int NFIELD     = 7;
  localparam int FREEZE_BIT = 6;

  typedef enum logic [2:0] {
    OFS_CTRL  = 3'd0,
    OFS_SEC   = 3'd1,
    OFS_MIN   = 3'd2,
    OFS_HOUR  = 3'd3,
    OFS_DAY   = 3'd4,
    OFS_DATE  = 3'd5,
    OFS_MONTH = 3'd6,
    OFS_YEAR  = 3'd7
  } win_ofs_e;

  // Bits that carry meaning in each window byte; the rest read as zero.
  function automatic logic [BYTE_W-1:0] field_mask(input logic [2:0] ofs);
    case (win_ofs_e'(ofs))
      OFS_CTRL:  field_mask = 8'h40;
      OFS_SEC:   field_mask = 8'h7F;
      OFS_MIN:   field_mask = 8'h7F;
      OFS_HOUR:  field_mask = 8'h3F;
      OFS_DAY:   field_mask = 8'h07;
      OFS_DATE:  field_mask = 8'h3F;
      OFS_MONTH: field_mask = 8'h1F;
      default:   field_mask = 8'hFF;
    endcase
  endfunction

  // True when the address lies in the eight highest locations.
  function automatic logic in_window(input logic [31:0] a, input int aw);
    logic [31:0] upper;
    upper = (32'h1 << aw) - 32'd8;
    in_window = (a >= upper);
  endfunction
endpackage

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rd_word = mem[addr];
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_win_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_wr,
  input  logic                          ctrl_freeze_bit,
  input  logic                          tick,
  input  logic [NFIELD-1:0][BYTE_W-1:0] live,
  output logic                          freeze_q,
  output logic [NFIELD-1:0][BYTE_W-1:0] hold_q
);
  // Named internal events, also used by the assertions.
  logic halt_set, halt_clear, tick_load, load_any;

  assign halt_set   = ctrl_wr &&  ctrl_freeze_bit && !freeze_q;
  assign halt_clear = ctrl_wr && !ctrl_freeze_bit &&  freeze_q;
  assign tick_load  = tick && !freeze_q && !halt_set;
  assign load_any   = halt_set || tick_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (halt_set)        freeze_q <= 1'b1;
      else if (halt_clear) freeze_q <= 1'b0;
      if (load_any)        hold_q   <= live;
    end
  end

  // R5: a freeze write captures the live count and sets the bit
  p_halt_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_set |=> (freeze_q && hold_q == $past(live)));

  // R6: the visible copy does not move while frozen
  p_frozen_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze_q) && freeze_q) |-> $stable(hold_q));

  // R4: an unfrozen tick reloads every field from the live inputs
  p_tick_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze_q && !ctrl_wr) |=> (hold_q == $past(live)));

  // R7: a release leaves the fields alone until a tick arrives
  p_release_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_clear && !tick) |=> (!freeze_q && hold_q == $past(hold_q)));
endmodule

// File: rtl/rtc_window.sv
module rtc_window
  import rtc_win_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              tick,
  input  logic [7:0]        live_sec,
  input  logic [7:0]        live_min,
  input  logic [7:0]        live_hour,
  input  logic [7:0]        live_day,
  input  logic [7:0]        live_date,
  input  logic [7:0]        live_month,
  input  logic [7:0]        live_year
);
  localparam int OFS_W = 3;

  logic                          win_sel;
  logic [OFS_W-1:0]              ofs;
  logic                          ram_we, ctrl_wr;
  logic [BYTE_W-1:0]             ram_word, win_word;
  logic                          freeze_q;
  logic [NFIELD-1:0][BYTE_W-1:0] live_bus, hold_q;

  assign win_sel = (addr[ADDR_W-1:OFS_W] == '1);
  assign ofs     = addr[OFS_W-1:0];
  assign ram_we  = wr_en && !win_sel;
  assign ctrl_wr = wr_en && win_sel && (ofs == OFS_CTRL);

  // Field index i holds offset i+1.
  assign live_bus = {live_year, live_month, live_date, live_day,
                     live_hour, live_min, live_sec};

  rtc_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .addr    (addr),
    .wdata   (wdata),
    .rd_word (ram_word)
  );

  rtc_shadow u_shadow (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctrl_wr         (ctrl_wr),
    .ctrl_freeze_bit (wdata[FREEZE_BIT]),
    .tick            (tick),
    .live            (live_bus),
    .freeze_q        (freeze_q),
    .hold_q          (hold_q)
  );

  always_comb begin
    win_word = '0;
    if (ofs == OFS_CTRL) begin
      win_word[FREEZE_BIT] = freeze_q;
    end else begin
      win_word = hold_q[ofs - 3'd1] & field_mask(ofs);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= win_sel ? win_word : ram_word;
  end

  // R8: a control read shows only the freeze bit
  p_ctrl_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && win_sel && ofs == OFS_CTRL) |=> ((rdata & 8'hBF) == 8'h00));

  // R8: a seconds read never carries bit 7
  p_sec_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && win_sel && ofs == OFS_SEC) |=> (rdata[7] == 1'b0));

  // R1: with no read strobe, the read register holds its value
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R9: a write to a time field leaves the visible copy alone unless a tick loads it
  p_field_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_sel && ofs != OFS_CTRL && !tick) |=> $stable(hold_q));
endmodule

// File: tb/rtc_window_test.sv
`timescale 1ns/1ps
module rtc_window_test;
  localparam int AW = 11;
  localparam logic [AW-1:0] WBASE = AW'((1 << AW) - 8);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] lv [7];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_window #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick(tick),
    .live_sec(lv[0]), .live_min(lv[1]), .live_hour(lv[2]), .live_day(lv[3]),
    .live_date(lv[4]), .live_month(lv[5]), .live_year(lv[6])
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_live(input logic [7:0] b);
    for (int i = 0; i < 7; i++) lv[i] = b + 8'(i);
  endtask

  function automatic logic [7:0] mask_of(input int i);
    case (i)
      0: return 8'h7F; 1: return 8'h7F; 2: return 8'h3F; 3: return 8'h07;
      4: return 8'h3F; 5: return 8'h1F; default: return 8'hFF;
    endcase
  endfunction

  // Reads offsets 1..7 and compares each against base+i under its mask.
  task automatic check_fields(input string tag, input logic [7:0] b);
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(WBASE + AW'(i + 1), d);
      chk(tag, d, (b + 8'(i)) & mask_of(i));
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 rdata after reset", rdata, 8'h00);
    rd(WBASE, d);               chk("R10 control after reset", d, 8'h00);
    rd(WBASE + AW'(1), d);      chk("R10 seconds after reset", d, 8'h00);
  endtask

  task automatic t_ram();
    logic [7:0] d;
    wr(AW'(0), 8'h12);
    wr(WBASE - AW'(1), 8'h34);
    rd(AW'(0), d);              chk("R1 RAM low byte", d, 8'h12);
    rd(WBASE - AW'(1), d);      chk("R1 RAM byte below window", d, 8'h34);
    wr(WBASE + AW'(1), 8'h55);  // field write: ignored
    rd(WBASE + AW'(1), d);      chk("R9 seconds write ignored", d, 8'h00);
    rd(WBASE - AW'(1), d);      chk("R9 RAM untouched by field write", d, 8'h34);
    rd(WBASE + AW'(2), d);      chk("R2 window read is not RAM", d, 8'h00);
  endtask

  task automatic t_tick_load();
    set_live(8'h10);
    pulse_tick();
    check_fields("R3 R4 tick reload layout", 8'h10);
  endtask

  task automatic t_masks();
    logic [7:0] d;
    for (int i = 0; i < 7; i++) lv[i] = 8'hFF;
    pulse_tick();
    for (int i = 0; i < 7; i++) begin
      rd(WBASE + AW'(i + 1), d);
      chk("R8 unused bits zero", d, mask_of(i));
    end
  endtask

  task automatic t_freeze();
    logic [7:0] d;
    set_live(8'h20);
    wr(WBASE, 8'hFF);           // bit 6 set; other bits do not stick
    rd(WBASE, d);               chk("R8 R5 control reads freeze only", d, 8'h40);
    set_live(8'h30);
    pulse_tick();
    pulse_tick();
    check_fields("R5 R6 frozen snapshot", 8'h20);
    wr(WBASE, 8'h40);           // already frozen: no recapture
    check_fields("R6 repeated freeze write", 8'h20);
  endtask

  task automatic t_release();
    logic [7:0] d;
    wr(WBASE, 8'h00);
    rd(WBASE, d);               chk("R7 control cleared", d, 8'h00);
    check_fields("R7 unchanged before tick", 8'h20);
    pulse_tick();
    check_fields("R7 reload at tick", 8'h30);
  endtask

  initial begin
    set_live(8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram();
    t_tick_load();
    t_masks();
    t_freeze();
    t_release();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule